// File: doc/BRIEF.md
# Multicycle Integer Core

This block is a 32-bit processor core for a small load/store instruction subset: register-to-register arithmetic and logic, word load, word store, branch on equal, and absolute jump. Each instruction is broken into steps of one clock each. Values pass between steps through internal holding registers: the instruction latch, the memory data latch, two operand latches and the ALU result latch. One ALU and one memory port serve every step, so an instruction needs three, four or five clocks depending on its kind.

A finite-state controller walks through fetch, decode, execute, memory and write-back. It drives the datapath through a packed struct of strobes. The single memory port carries both instruction fetches and data accesses. The read data path is combinational: the word at the presented address is expected on the read-data input within the same cycle. A write is committed at the clock edge that ends the cycle in which the write enable is high.

Top module: `mc_core`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, PC is cleared to 0 and the controller is put in the fetch step. In the fetch step the memory address equals PC and the write enable is low.
- R2: The fetch step latches the word at PC into the instruction latch and advances PC by 4 in the same cycle.
- R3: The decode step loads the operand latches from the registers named by bits 25:21 and 20:16. It also uses the ALU to compute the branch target, PC plus the sign-extended bits 15:0 shifted left by two, where PC has already been advanced past the branch.
- R4: Opcode 0 is a register operation. The funct field bits 5:0 select the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than. The result goes to the register named by bits 15:11.
- R5: Opcode 0x23 (load) and opcode 0x2B (store) use the address formed by adding the register named by bits 25:21 to the sign-extended bits 15:0, so negative offsets work. A load writes the fetched word to the register named by bits 20:16. A store writes that register to memory.
- R6: Opcode 0x04 branches to the decode-step target when the two registers are equal. Otherwise PC is left unchanged.
- R7: Opcode 0x02 sets PC to the upper four bits of the advanced PC, followed by bits 25:0 shifted left by two.
- R8: A branch or jump takes 3 cycles, a register operation or store 4, and a load 5. A store drives the write enable in its fourth cycle.
- R9: Register 0 always reads as zero. Writes to register 0 have no effect.
- R10: An unrecognised opcode, or opcode 0 with an unrecognised funct, returns the controller to fetch after decode. Such an instruction takes 2 cycles and changes no register, memory word or PC beyond the fetch increment.
- R11: No cycle both accesses data memory and writes the register file or the ALU result latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | 32 | Byte address of the shared memory port |
| memWdata | output | 32 | Store data |
| memRdata | input | 32 | Read data for the current address, valid in the same cycle |
| memWe | output | 1 | Write enable, the write is taken at the end of the cycle |

## Verification
The hardest situations to reach from the ports are those in which an instruction must leave no trace: an illegal opcode or funct, a write to register 0, a branch not taken, and the instructions skipped by a taken branch or a jump. The bench runs small programs from a bench-side memory. Every register value that matters is copied to a distinct memory word by a later store, so the contents of the register file become visible as memory words. The bench also notes the cycle in which the first write enable appears after reset. Those cycle numbers show that each instruction kind takes its expected number of steps and that an illegal instruction costs exactly two cycles.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_JUMP  = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {PC_FROM_ALU, PC_FROM_ALUOUT, PC_FROM_JUMP} pcSel_e;
  typedef enum logic [1:0] {SRCB_REG, SRCB_FOUR, SRCB_IMM, SRCB_BOFF} srcB_e;
  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} aluFn_e;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_EXEC_R, ST_EXEC_ADDR, ST_EXEC_BR, ST_EXEC_J,
    ST_WB_R, ST_MEM_RD, ST_MEM_WR, ST_WB_LD
  } state_e;

  typedef struct packed {
    logic   irWrite;
    logic   pcWrite;
    logic   pcCond;
    pcSel_e pcSel;
    logic   srcAReg;
    srcB_e  srcB;
    aluFn_e aluFn;
    logic   abWrite;
    logic   aluOutWrite;
    logic   addrFromAluOut;
    logic   memWe;
    logic   mdrWrite;
    logic   regWrite;
    logic   dstRd;
    logic   wbFromMdr;
  } ctrl_t;

endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  aluFn_e       fn,
  output logic [W-1:0] result,
  output logic         isZero
);
  logic lessThan;
  assign lessThan = $signed(opA) < $signed(opB);

  always_comb begin
    unique case (fn)
      ALU_ADD: result = opA + opB;
      ALU_SUB: result = opA - opB;
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_SLT: result = {{(W-1){1'b0}}, lessThan};
      default: result = '0;
    endcase
  end

  assign isZero = (result == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] rdAddrA,
  input  logic [AW-1:0] rdAddrB,
  output logic [W-1:0]  rdDataA,
  output logic [W-1:0]  rdDataB,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [W-1:0]  wrData
);
  logic [W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn && wrAddr != '0) regs[wrAddr] <= wrData;
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];
endmodule

// File: rtl/mc_control.sv
module mc_control
  import mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  state_e state, stateNext;

  function automatic logic knownFunct(input logic [5:0] f);
    return (f == FN_ADD) || (f == FN_SUB) || (f == FN_AND) ||
           (f == FN_OR) || (f == FN_SLT);
  endfunction

  function automatic aluFn_e functToAlu(input logic [5:0] f);
    unique case (f)
      FN_SUB:  return ALU_SUB;
      FN_AND:  return ALU_AND;
      FN_OR:   return ALU_OR;
      FN_SLT:  return ALU_SLT;
      default: return ALU_ADD;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = ST_FETCH;
    unique case (state)
      ST_FETCH:  stateNext = ST_DECODE;
      ST_DECODE: begin
        unique case (opcode)
          OP_RTYPE: stateNext = knownFunct(funct) ? ST_EXEC_R : ST_FETCH;
          OP_LOAD,
          OP_STORE: stateNext = ST_EXEC_ADDR;
          OP_BEQ:   stateNext = ST_EXEC_BR;
          OP_JUMP:  stateNext = ST_EXEC_J;
          default:  stateNext = ST_FETCH;
        endcase
      end
      ST_EXEC_R:    stateNext = ST_WB_R;
      ST_EXEC_ADDR: stateNext = (opcode == OP_LOAD) ? ST_MEM_RD : ST_MEM_WR;
      ST_MEM_RD:    stateNext = ST_WB_LD;
      default:      stateNext = ST_FETCH;
    endcase
  end

  always_comb begin
    ctrl = '0;
    unique case (state)
      ST_FETCH: begin
        ctrl.irWrite = 1'b1;
        ctrl.pcWrite = 1'b1;
        ctrl.pcSel   = PC_FROM_ALU;
        ctrl.srcB    = SRCB_FOUR;
        ctrl.aluFn   = ALU_ADD;
      end
      ST_DECODE: begin
        ctrl.abWrite     = 1'b1;
        ctrl.aluOutWrite = 1'b1;
        ctrl.srcB        = SRCB_BOFF;
        ctrl.aluFn       = ALU_ADD;
      end
      ST_EXEC_R: begin
        ctrl.srcAReg     = 1'b1;
        ctrl.srcB        = SRCB_REG;
        ctrl.aluFn       = functToAlu(funct);
        ctrl.aluOutWrite = 1'b1;
      end
      ST_EXEC_ADDR: begin
        ctrl.srcAReg     = 1'b1;
        ctrl.srcB        = SRCB_IMM;
        ctrl.aluFn       = ALU_ADD;
        ctrl.aluOutWrite = 1'b1;
      end
      ST_EXEC_BR: begin
        ctrl.srcAReg = 1'b1;
        ctrl.srcB    = SRCB_REG;
        ctrl.aluFn   = ALU_SUB;
        ctrl.pcCond  = 1'b1;
        ctrl.pcSel   = PC_FROM_ALUOUT;
      end
      ST_EXEC_J: begin
        ctrl.pcWrite = 1'b1;
        ctrl.pcSel   = PC_FROM_JUMP;
      end
      ST_WB_R: begin
        ctrl.regWrite = 1'b1;
        ctrl.dstRd    = 1'b1;
      end
      ST_MEM_RD: begin
        ctrl.addrFromAluOut = 1'b1;
        ctrl.mdrWrite       = 1'b1;
      end
      ST_MEM_WR: begin
        ctrl.addrFromAluOut = 1'b1;
        ctrl.memWe          = 1'b1;
      end
      ST_WB_LD: begin
        ctrl.regWrite  = 1'b1;
        ctrl.wbFromMdr = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end

  // R8: every fetch is followed by a decode
  a_r8_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |=> (state == ST_DECODE));

  // R10: an illegal opcode returns to fetch straight after decode
  a_r10_illegal_to_fetch: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECODE && opcode != OP_RTYPE && opcode != OP_LOAD &&
     opcode != OP_STORE && opcode != OP_BEQ && opcode != OP_JUMP)
    |=> (state == ST_FETCH));

  // R11: a data memory cycle never also writes registers or the result latch
  a_r11_one_unit: assert property (@(posedge clk) disable iff (rst)
    (ctrl.memWe || ctrl.mdrWrite) |-> !(ctrl.regWrite || ctrl.aluOutWrite));

  // R8: a store completes in its fourth cycle
  a_r8_store_ends: assert property (@(posedge clk) disable iff (rst)
    ctrl.memWe |=> (state == ST_FETCH));
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int RAW  = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  ctrl_t           ctrl,
  output logic [5:0]      opcode,
  output logic [5:0]      funct,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWdata,
  input  logic [XLEN-1:0] memRdata
);
  logic [XLEN-1:0] pc, ir, mdr, opRegA, opRegB, aluOut;
  logic [XLEN-1:0] rfA, rfB, srcA, srcB, aluRes, pcNext, immExt, wbData;
  logic [RAW-1:0]  wbAddr;
  logic            aluZero;

  assign opcode = ir[31:26];
  assign funct  = ir[5:0];
  assign immExt = {{(XLEN-16){ir[15]}}, ir[15:0]};

  mc_regfile #(.W(XLEN), .DEPTH(NREGS)) u_rf (
    .clk     (clk),
    .rdAddrA (ir[25:21]),
    .rdAddrB (ir[20:16]),
    .rdDataA (rfA),
    .rdDataB (rfB),
    .wrEn    (ctrl.regWrite),
    .wrAddr  (wbAddr),
    .wrData  (wbData)
  );

  assign wbAddr = ctrl.dstRd ? ir[15:11] : ir[20:16];
  assign wbData = ctrl.wbFromMdr ? mdr : aluOut;

  assign srcA = ctrl.srcAReg ? opRegA : pc;
  always_comb begin
    unique case (ctrl.srcB)
      SRCB_REG:  srcB = opRegB;
      SRCB_FOUR: srcB = XLEN'(4);
      SRCB_IMM:  srcB = immExt;
      default:   srcB = {immExt[XLEN-3:0], 2'b00};
    endcase
  end

  mc_alu #(.W(XLEN)) u_alu (
    .opA    (srcA),
    .opB    (srcB),
    .fn     (ctrl.aluFn),
    .result (aluRes),
    .isZero (aluZero)
  );

  always_comb begin
    unique case (ctrl.pcSel)
      PC_FROM_ALUOUT: pcNext = aluOut;
      PC_FROM_JUMP:   pcNext = {pc[XLEN-1:28], ir[25:0], 2'b00};
      default:        pcNext = aluRes;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
    end else if (ctrl.pcWrite || (ctrl.pcCond && aluZero)) begin
      pc <= pcNext;
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.irWrite)     ir     <= memRdata;
    if (ctrl.mdrWrite)    mdr    <= memRdata;
    if (ctrl.aluOutWrite) aluOut <= aluRes;
    if (ctrl.abWrite) begin
      opRegA <= rfA;
      opRegB <= rfB;
    end
  end

  assign memAddr  = ctrl.addrFromAluOut ? aluOut : pc;
  assign memWdata = opRegB;

  // R2: fetch advances PC by one word
  a_r2_fetch_step: assert property (@(posedge clk) disable iff (rst)
    ctrl.irWrite |=> (pc == $past(pc) + XLEN'(4)));

  // R6: a branch with unequal operands leaves PC alone
  a_r6_not_taken: assert property (@(posedge clk) disable iff (rst)
    (ctrl.pcCond && opRegA != opRegB) |=> (pc == $past(pc)));

  // R9: register 0 always reads as zero into the operand latch
  a_r9_zero_reg: assert property (@(posedge clk) disable iff (rst)
    (ctrl.abWrite && ir[25:21] == '0) |=> (opRegA == '0));
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWdata,
  input  logic [XLEN-1:0] memRdata,
  output logic            memWe
);
  ctrl_t      ctrl;
  logic [5:0] opcode, funct;

  mc_control u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl)
  );

  mc_datapath #(.XLEN(XLEN), .NREGS(NREGS)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .opcode   (opcode),
    .funct    (funct),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memRdata (memRdata)
  );

  assign memWe = ctrl.memWe;

  // R1: no memory write while reset is held
  a_r1_reset_quiet: assert property (@(posedge clk) rst |-> !memWe);
endmodule

// File: tb/sim_mc_core.sv
module sim_mc_core;
  localparam int CLK_PERIOD = 10;
  localparam int MEMW = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] memAddr, memWdata, memRdata;
  logic        memWe;

  logic [31:0] mem [MEMW];
  int nChecks = 0;
  int nFails  = 0;
  int cyc = 0;
  int wrCnt = 0;
  int firstWrCyc = -1;
  int totalCyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_core u0 (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memWe(memWe)
  );

  assign memRdata = mem[memAddr[9:2]];
  always @(posedge clk) if (memWe) mem[memAddr[9:2]] <= memWdata;

  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; wrCnt = 0; firstWrCyc = -1;
    end else begin
      if (memWe) begin
        wrCnt++;
        if (firstWrCyc < 0) firstWrCyc = cyc;
      end
      cyc++;
    end
  end

  always @(posedge clk) begin
    totalCyc++;
    if (totalCyc > 20000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", totalCyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  function automatic logic [31:0] encR(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] encI(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] encJ(input int target);
    return {6'h02, 26'(target)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    @(posedge clk); #1 rst = 1'b1;
    for (int i = 0; i < MEMW; i++) mem[i] = 32'h0;
    mem[8'h40] = 32'd7;
    mem[8'h41] = 32'hFFFF_FFFD;
    mem[8'h42] = 32'h0000_0300;
  endtask

  task automatic runCycles(input int n);
    @(posedge clk); #1 rst = 1'b0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset address", memAddr, 32'h0);
    check("R1 reset write enable", {31'b0, memWe}, 32'h0);
  endtask

  task automatic testAluOps();
    clearMem();
    mem[0]  = encI(6'h23, 0, 1, 'h100);
    mem[1]  = encI(6'h23, 0, 2, 'h104);
    mem[2]  = encR(1, 2, 3, 6'h20);
    mem[3]  = encR(1, 2, 4, 6'h22);
    mem[4]  = encR(1, 2, 5, 6'h24);
    mem[5]  = encR(1, 2, 6, 6'h25);
    mem[6]  = encR(1, 2, 7, 6'h2A);
    mem[7]  = encR(2, 1, 8, 6'h2A);
    for (int k = 0; k < 6; k++) mem[8+k] = encI(6'h2B, 0, 3+k, 'h200 + 4*k);
    mem[14] = encJ(14);
    runCycles(90);
    check("R4 add", mem[8'h80], 32'd4);
    check("R4 sub", mem[8'h81], 32'd10);
    check("R4 and", mem[8'h82], 32'd5);
    check("R4 or", mem[8'h83], 32'hFFFF_FFFF);
    check("R4 slt false", mem[8'h84], 32'd0);
    check("R4 slt true signed", mem[8'h85], 32'd1);
    check("R8 first store cycle after 2 loads and 6 R-ops", firstWrCyc, 32'd37);
    check("R8 store count", wrCnt, 32'd6);
  endtask

  task automatic testZeroRegAndOffsets();
    clearMem();
    mem[0] = encI(6'h23, 0, 1, 'h100);
    mem[1] = encR(1, 1, 0, 6'h20);
    mem[2] = encI(6'h23, 0, 0, 'h100);
    mem[3] = encR(0, 1, 2, 6'h20);
    mem[4] = encI(6'h2B, 0, 0, 'h200);
    mem[5] = encI(6'h2B, 0, 2, 'h204);
    mem[6] = encI(6'h23, 0, 9, 'h108);
    mem[7] = encI(6'h2B, 9, 1, -8);
    mem[8] = encI(6'h23, 9, 4, -8);
    mem[9] = encI(6'h2B, 0, 4, 'h20C);
    mem[10] = encJ(10);
    runCycles(80);
    check("R9 r0 after writes", mem[8'h80], 32'd0);
    check("R9 r0 reads zero as source", mem[8'h81], 32'd7);
    check("R5 store negative offset", mem[8'hBE], 32'd7);
    check("R5 load negative offset", mem[8'h83], 32'd7);
  endtask

  task automatic testBranch();
    clearMem();
    mem[0] = encI(6'h23, 0, 1, 'h100);
    mem[1] = encI(6'h23, 0, 2, 'h104);
    mem[2] = encI(6'h04, 1, 2, 1);
    mem[3] = encI(6'h2B, 0, 1, 'h200);
    mem[4] = encI(6'h04, 1, 1, 1);
    mem[5] = encI(6'h2B, 0, 2, 'h204);
    mem[6] = encI(6'h2B, 0, 2, 'h208);
    mem[7] = encI(6'h04, 0, 0, -1);
    runCycles(60);
    check("R6 not taken falls through", mem[8'h80], 32'd7);
    check("R6 taken skips store", mem[8'h81], 32'd0);
    check("R3 taken target reached", mem[8'h82], 32'hFFFF_FFFD);
    check("R8 branch 3 cycles: first store", firstWrCyc, 32'd16);
    check("R6 backward self-branch halts, store count", wrCnt, 32'd2);
  endtask

  task automatic testJump();
    clearMem();
    mem[0] = encI(6'h23, 0, 1, 'h100);
    mem[1] = encJ(4);
    mem[2] = encI(6'h2B, 0, 1, 'h200);
    mem[3] = encI(6'h2B, 0, 1, 'h204);
    mem[4] = encI(6'h2B, 0, 1, 'h208);
    mem[5] = encJ(5);
    runCycles(40);
    check("R7 skipped word 2", mem[8'h80], 32'd0);
    check("R7 skipped word 3", mem[8'h81], 32'd0);
    check("R7 jump target executed", mem[8'h82], 32'd7);
    check("R8 jump 3 cycles", firstWrCyc, 32'd11);
  endtask

  task automatic testIllegal();
    clearMem();
    mem[0] = encI(6'h23, 0, 1, 'h100);
    mem[1] = encI(6'h3F, 0, 1, 'h104);
    mem[2] = encR(0, 0, 1, 6'h3F);
    mem[3] = encI(6'h2B, 0, 1, 'h200);
    mem[4] = encJ(4);
    runCycles(40);
    check("R10 illegal leaves r1", mem[8'h80], 32'd7);
    check("R10 two illegal words cost 2 cycles each", firstWrCyc, 32'd12);
    check("R10 no stray memory writes", wrCnt, 32'd1);
  endtask

  initial begin
    testReset();
    testAluOps();
    testReset();
    testZeroRegAndOffsets();
    testBranch();
    testJump();
    testIllegal();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule